// File: doc/BRIEF.md
# Super I/O Configuration Register Controller

This block is the byte-wide setup front end of a multi-function I/O controller. It answers at two adjacent host addresses. The first is an index/key port and the second is a data port. The pair sits at 0x2E, or at 0x4E when the `strap_alt` input is high. Software first writes an unlock key to the index port. It then picks a register by writing its number to the index port, and reads or writes that register through the data port. A lock key closes the register space again.

Register numbers below 0x30 reach a bank of global registers. Numbers from 0x30 up reach the register bank of one logical device, chosen by global register 0x07. Logical devices 4 and 5 are serial ports. Their enable, 16-bit I/O base and IRQ number are sent to downstream decode logic only when the lock key closes a configuration session. For each enabled serial port the block also drives a registered chip-select whenever a host access falls in the 8-byte window that starts at that port's base.

Top module: `sio_cfg_ctrl`

## Requirements
- R1: The block decodes exactly two host addresses. The index port is at base and the data port at base+1. The base is 0x2E when `strap_alt`=0 and 0x4E when `strap_alt`=1. An access to any other address leaves the configuration state and `host_rdata` unchanged.
- R2: Writing 0x55 to the index port turns configuration mode on. Writing 0xAA to the index port turns it off. Both keys act whether or not configuration mode is already on.
- R3: While configuration mode is off, index-port writes other than the two keys, and all data-port writes, change neither the index nor any register.
- R4: While configuration mode is on, an index-port write that is not a key loads the register index. A data-port write stores its byte into the selected register. A data-port read returns that register on `host_rdata` one clock after the read is sampled.
- R5: Index values 0x00 to 0x2F select the global bank. Index values 0x30 to 0xFF select the bank of the logical device numbered in global register 0x07.
- R6: Logical devices 0x00 to 0x0B exist. When global 0x07 holds 0x0C or more, device-bank writes are dropped and device-bank reads return 0x00.
- R7: Port 0 is logical device 4 and port 1 is logical device 5. When 0xAA is written while configuration mode is on, each port takes the following values. Enable becomes (reg 0x30 != 0). If enabled, the base becomes {reg 0x60, reg 0x61} and the IRQ becomes reg 0x70 bits [3:0]. If disabled, the base and IRQ keep their previous values. The published values change at no other time, including on 0xAA written outside configuration mode.
- R8: Synchronous reset sets all of the following. Configuration mode is off and the index is 0. Global 0x26 holds the base low byte, global 0x27 holds the base high byte, and every other global register is 0. Every device register reads 0. Both ports are disabled with base 0 and IRQ 0. `host_rdata` is 0.
- R9: A read of the index port returns 0x00. A data-port read while configuration mode is off returns 0x00.
- R10: `ser_cs[i]` is high in the clock after a sampled read or write whose address A satisfies base_i <= A <= base_i+7, provided port i was enabled. The window does not wrap past 0xFFFF.
- R11: Each logical device bank is separate. A write to a device register leaves the same index in every other device unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_alt | input | 1 | Base select: 0 gives 0x2E, 1 gives 0x4E (static) |
| host_addr | input | 16 | Host I/O address |
| host_wr | input | 1 | Single-byte write strobe, one cycle |
| host_rd | input | 1 | Single-byte read strobe, one cycle |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data, held until the next read of the block |
| ser_en | output | 2 | Published enable per serial port |
| ser_base | output | 32 | Published I/O base, port 0 in [15:0], port 1 in [31:16] |
| ser_irq | output | 8 | Published IRQ, port 0 in [3:0], port 1 in [7:4]; 0 means none |
| ser_cs | output | 2 | Registered chip-select for each port's 8-byte window |

## Verification
The embedded properties are checked on every cycle. They cover the following:
- key entry and exit;
- the index staying frozen while unlocked mode is off;
- zero data from index-port and bad-device reads;
- published serial settings staying still except on an effective exit key;
- a disable leaving the base in place;
- chip-selects appearing only for a previously enabled port.

Stored byte values need a reference model of both banks, and only the bench scenarios can show them. The same holds for the device select steering data between banks, for the exact window edges at 0x3FF/0x400 and at the top of the address space, and for the strap moving the block.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam logic [7:0] KEY_UNLOCK   = 8'h55;
  localparam logic [7:0] KEY_LOCK     = 8'hAA;

  localparam logic [7:0] REG_DEV_SEL  = 8'h07;
  localparam logic [7:0] REG_SELF_LO  = 8'h26;
  localparam logic [7:0] REG_SELF_HI  = 8'h27;

  localparam logic [7:0] REG_ACTIVE   = 8'h30;
  localparam logic [7:0] REG_IOB_HI   = 8'h60;
  localparam logic [7:0] REG_IOB_LO   = 8'h61;
  localparam logic [7:0] REG_INTLINE  = 8'h70;

  typedef struct packed {
    logic        en;
    logic [15:0] base;
    logic [3:0]  irq;
  } ser_cfg_t;

endpackage

// File: rtl/sio_host_if.sv
module sio_host_if
  import sio_cfg_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BASE_DEF = 'h2E,
  parameter int BASE_ALT = 'h4E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_alt,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [ADDR_W-1:0] port_base,
  output logic [7:0]        index,
  output logic              data_wr,
  output logic              lock_stb,
  output logic              rd_hit,
  output logic              rd_sel_data
);

  logic cfg_q;
  logic [7:0] idx_q;
  logic hit_idx, hit_dat, is_unlock, is_lock;

  assign port_base = strap_alt ? ADDR_W'(BASE_ALT) : ADDR_W'(BASE_DEF);
  assign hit_idx   = (host_addr == port_base);
  assign hit_dat   = (host_addr == port_base + ADDR_W'(1));
  assign is_unlock = (host_wdata == KEY_UNLOCK);
  assign is_lock   = (host_wdata == KEY_LOCK);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= 1'b0;
      idx_q <= 8'h00;
    end else if (host_wr && hit_idx) begin
      if (is_unlock)      cfg_q <= 1'b1;
      else if (is_lock)   cfg_q <= 1'b0;
      else if (cfg_q)     idx_q <= host_wdata;
    end
  end

  assign index       = idx_q;
  assign data_wr     = host_wr && hit_dat && cfg_q;
  assign lock_stb    = host_wr && hit_idx && is_lock && cfg_q;
  assign rd_hit      = host_rd && (hit_idx || hit_dat);
  assign rd_sel_data = host_rd && hit_dat && cfg_q;

  // R2: keys take effect in any mode
  a_r2_unlock: assert property (@(posedge clk) disable iff (rst)
    (host_wr && hit_idx && is_unlock) |=> cfg_q);
  a_r2_lock: assert property (@(posedge clk) disable iff (rst)
    (host_wr && hit_idx && is_lock) |=> !cfg_q);
  // R3: index frozen while locked
  a_r3_idx_frozen: assert property (@(posedge clk) disable iff (rst)
    !cfg_q |=> $stable(idx_q));

endmodule

// File: rtl/sio_reg_store.sv
module sio_reg_store
  import sio_cfg_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int GLOB_REGS = 48,
  parameter int NUM_DEV   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] port_base,
  input  logic [7:0]        index,
  input  logic [7:0]        wdata,
  input  logic              data_wr,
  input  logic              rd_hit,
  input  logic              rd_sel_data,
  output logic [7:0]        rdata,
  output logic [7:0]        dev_sel
);

  localparam int DEV_REGS  = 256 - GLOB_REGS;
  localparam int MEM_DEPTH = NUM_DEV * DEV_REGS;
  localparam int MEM_AW    = $clog2(MEM_DEPTH);
  localparam int GW        = $clog2(GLOB_REGS);

  logic [7:0]           glob_q [GLOB_REGS];
  logic [7:0]           mem    [MEM_DEPTH];
  logic [MEM_DEPTH-1:0] vld_q;
  logic [7:0]           rdata_q;
  logic                 is_glob, dev_ok;
  logic [MEM_AW-1:0]    mem_addr;

  assign dev_sel  = glob_q[REG_DEV_SEL[GW-1:0]];
  assign is_glob  = (index < 8'(GLOB_REGS));
  assign dev_ok   = (dev_sel < 8'(NUM_DEV));
  assign mem_addr = MEM_AW'(32'(dev_sel) * 32'(DEV_REGS) + 32'(index) - 32'(GLOB_REGS));

  // global bank: flops with reset, own base mirrored at reset
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < GLOB_REGS; g++) begin
        if (g == int'(REG_SELF_LO))      glob_q[g] <= port_base[7:0];
        else if (g == int'(REG_SELF_HI)) glob_q[g] <= 8'(port_base >> 8);
        else                             glob_q[g] <= 8'h00;
      end
    end else if (data_wr && is_glob) begin
      glob_q[index[GW-1:0]] <= wdata;
    end
  end

  // device banks: plain RAM, no reset on the array
  always_ff @(posedge clk) begin
    if (data_wr && !is_glob && dev_ok) mem[mem_addr] <= wdata;
  end

  // per-entry written flags give the reset-to-zero view
  always_ff @(posedge clk) begin
    if (rst)                                vld_q <= '0;
    else if (data_wr && !is_glob && dev_ok) vld_q[mem_addr] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= 8'h00;
    end else if (rd_hit) begin
      if (!rd_sel_data)                 rdata_q <= 8'h00;
      else if (is_glob)                 rdata_q <= glob_q[index[GW-1:0]];
      else if (dev_ok && vld_q[mem_addr]) rdata_q <= mem[mem_addr];
      else                              rdata_q <= 8'h00;
    end
  end

  assign rdata = rdata_q;

  // R9: index port and locked reads give zero
  a_r9_zero_read: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && !rd_sel_data) |=> (rdata == 8'h00));
  // R6: missing device reads as zero
  a_r6_bad_dev_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_sel_data && !is_glob && !dev_ok) |=> (rdata == 8'h00));
  // R1: a cycle without a block read keeps the read data
  a_r1_hold_rdata: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> $stable(rdata));

endmodule

// File: rtl/sio_ser_port.sv
module sio_ser_port
  import sio_cfg_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DEV_ID    = 4,
  parameter int WIN_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        index,
  input  logic [7:0]        dev_sel,
  input  logic [7:0]        wdata,
  input  logic              data_wr,
  input  logic              lock_stb,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_access,
  output ser_cfg_t          pub,
  output logic              cs
);

  logic       act_s;
  logic [7:0] bhi_s, blo_s;
  logic [3:0] irq_s;
  ser_cfg_t   pub_q;
  logic       cs_q;
  logic [ADDR_W:0] diff;
  logic       in_win, mine;

  assign mine = data_wr && (dev_sel == 8'(DEV_ID));

  // shadow of the decode fields, tracking the device bank contents
  always_ff @(posedge clk) begin
    if (rst) begin
      act_s <= 1'b0;
      bhi_s <= 8'h00;
      blo_s <= 8'h00;
      irq_s <= 4'h0;
    end else if (mine) begin
      case (index)
        REG_ACTIVE:  act_s <= |wdata;
        REG_IOB_HI:  bhi_s <= wdata;
        REG_IOB_LO:  blo_s <= wdata;
        REG_INTLINE: irq_s <= wdata[3:0];
        default: ;
      endcase
    end
  end

  // publish on an effective lock key
  always_ff @(posedge clk) begin
    if (rst) begin
      pub_q <= '0;
    end else if (lock_stb) begin
      pub_q.en <= act_s;
      if (act_s) begin
        pub_q.base <= {bhi_s, blo_s};
        pub_q.irq  <= irq_s;
      end
    end
  end

  assign diff   = {1'b0, host_addr} - {1'b0, ADDR_W'(pub_q.base)};
  assign in_win = (diff < (ADDR_W+1)'(WIN_BYTES));

  always_ff @(posedge clk) begin
    if (rst) cs_q <= 1'b0;
    else     cs_q <= pub_q.en && host_access && in_win;
  end

  assign pub = pub_q;
  assign cs  = cs_q;

  // R7: outputs move only on an effective lock key
  a_r7_stable: assert property (@(posedge clk) disable iff (rst)
    !lock_stb |=> ($stable(pub_q.en) && $stable(pub_q.base) && $stable(pub_q.irq)));
  a_r7_off_keeps_base: assert property (@(posedge clk) disable iff (rst)
    (lock_stb && !act_s) |=> (!pub_q.en && $stable(pub_q.base) && $stable(pub_q.irq)));
  // R10: chip-select only for a port enabled the cycle before
  a_r10_cs_needs_en: assert property (@(posedge clk) disable iff (rst)
    cs_q |-> $past(pub_q.en));

endmodule

// File: rtl/sio_cfg_ctrl.sv
module sio_cfg_ctrl
  import sio_cfg_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BASE_DEF  = 'h2E,
  parameter int BASE_ALT  = 'h4E,
  parameter int GLOB_REGS = 48,
  parameter int NUM_DEV   = 12,
  parameter int NUM_SER   = 2,
  parameter int SER_DEV0  = 4,
  parameter int WIN_BYTES = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 strap_alt,
  input  logic [ADDR_W-1:0]    host_addr,
  input  logic                 host_wr,
  input  logic                 host_rd,
  input  logic [7:0]           host_wdata,
  output logic [7:0]           host_rdata,
  output logic [NUM_SER-1:0]   ser_en,
  output logic [NUM_SER*16-1:0] ser_base,
  output logic [NUM_SER*4-1:0] ser_irq,
  output logic [NUM_SER-1:0]   ser_cs
);

  logic [ADDR_W-1:0] port_base;
  logic [7:0]        index, dev_sel;
  logic              data_wr, lock_stb, rd_hit, rd_sel_data;

  sio_host_if #(
    .ADDR_W(ADDR_W), .BASE_DEF(BASE_DEF), .BASE_ALT(BASE_ALT)
  ) u_host (
    .clk(clk), .rst(rst), .strap_alt(strap_alt),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .port_base(port_base), .index(index),
    .data_wr(data_wr), .lock_stb(lock_stb), .rd_hit(rd_hit),
    .rd_sel_data(rd_sel_data)
  );

  sio_reg_store #(
    .ADDR_W(ADDR_W), .GLOB_REGS(GLOB_REGS), .NUM_DEV(NUM_DEV)
  ) u_store (
    .clk(clk), .rst(rst), .port_base(port_base), .index(index),
    .wdata(host_wdata), .data_wr(data_wr), .rd_hit(rd_hit),
    .rd_sel_data(rd_sel_data), .rdata(host_rdata), .dev_sel(dev_sel)
  );

  for (genvar p = 0; p < NUM_SER; p++) begin : g_ser
    ser_cfg_t pub;
    sio_ser_port #(
      .ADDR_W(ADDR_W), .DEV_ID(SER_DEV0 + p), .WIN_BYTES(WIN_BYTES)
    ) u_port (
      .clk(clk), .rst(rst), .index(index), .dev_sel(dev_sel),
      .wdata(host_wdata), .data_wr(data_wr), .lock_stb(lock_stb),
      .host_addr(host_addr), .host_access(host_rd || host_wr),
      .pub(pub), .cs(ser_cs[p])
    );
    assign ser_en[p]          = pub.en;
    assign ser_base[p*16 +: 16] = pub.base;
    assign ser_irq[p*4 +: 4]  = pub.irq;
  end

  initial begin
    a_cfg_params: assert (SER_DEV0 + NUM_SER <= NUM_DEV && ADDR_W >= 16
                          && GLOB_REGS <= 255);
  end

endmodule

// File: tb/test_sio_cfg_ctrl.sv
`timescale 1ns/1ps
module test_sio_cfg_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strap_alt = 1'b0;
  logic [15:0] host_addr = 16'h0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_wdata = 8'h0;
  logic [7:0]  host_rdata;
  logic [1:0]  ser_en, ser_cs;
  logic [31:0] ser_base;
  logic [7:0]  ser_irq;

  sio_cfg_ctrl i_sio_cfg_ctrl (
    .clk(clk), .rst(rst), .strap_alt(strap_alt), .host_addr(host_addr),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .ser_en(ser_en), .ser_base(ser_base),
    .ser_irq(ser_irq), .ser_cs(ser_cs)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;

  // reference model
  logic        m_cfg;
  logic [7:0]  m_idx, m_rdata;
  logic [7:0]  m_glob [48];
  logic [7:0]  m_dev  [12][208];
  logic        m_en   [2];
  logic [15:0] m_base [2];
  logic [3:0]  m_irq  [2];

  function automatic logic [15:0] bport();
    return strap_alt ? 16'h004E : 16'h002E;
  endfunction

  function automatic logic [7:0] exp_data();
    if (!m_cfg) return 8'h00;
    if (m_idx < 8'd48) return m_glob[m_idx];
    if (m_glob[7] < 8'd12) return m_dev[m_glob[7]][m_idx - 8'd48];
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic model_reset();
    m_cfg = 0; m_idx = 0; m_rdata = 0;
    for (int g = 0; g < 48; g++) m_glob[g] = 8'h00;
    m_glob[8'h26] = bport()[7:0];
    m_glob[8'h27] = bport()[15:8];
    for (int d = 0; d < 12; d++)
      for (int r = 0; r < 208; r++) m_dev[d][r] = 8'h00;
    for (int p = 0; p < 2; p++) begin m_en[p] = 0; m_base[p] = 0; m_irq[p] = 0; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; host_wr = 0; host_rd = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic check_outputs(input string req);
    chk(req, host_rdata, m_rdata);
    chk("R7", {ser_en, ser_irq, ser_base},
        {m_en[1], m_en[0], m_irq[1], m_irq[0], m_base[1], m_base[0]});
  endtask

  task automatic access(input bit wr, input bit rd, input logic [15:0] a,
                        input logic [7:0] d, input string req);
    logic [1:0] exp_cs;
    @(negedge clk);
    host_wr = wr; host_rd = rd; host_addr = a; host_wdata = d;
    for (int p = 0; p < 2; p++)
      exp_cs[p] = m_en[p] && (wr || rd) && ({1'b0, a} >= {1'b0, m_base[p]})
                  && ({1'b0, a} - {1'b0, m_base[p]} < 17'd8);
    if (rd && (a == bport() || a == bport() + 16'd1))
      m_rdata = (a == bport() + 16'd1) ? exp_data() : 8'h00;
    if (wr && a == bport()) begin
      if (d == 8'h55) m_cfg = 1;
      else if (d == 8'hAA) begin
        if (m_cfg)
          for (int p = 0; p < 2; p++) begin
            m_en[p] = (m_dev[4+p][8'h00] != 8'h00);
            if (m_en[p]) begin
              m_base[p] = {m_dev[4+p][8'h30], m_dev[4+p][8'h31]};
              m_irq[p]  = m_dev[4+p][8'h40][3:0];
            end
          end
        m_cfg = 0;
      end else if (m_cfg) m_idx = d;
    end else if (wr && a == bport() + 16'd1 && m_cfg) begin
      if (m_idx < 8'd48) m_glob[m_idx] = d;
      else if (m_glob[7] < 8'd12) m_dev[m_glob[7]][m_idx - 8'd48] = d;
    end
    @(posedge clk); #1;
    check_outputs(req);
    chk("R10", ser_cs, exp_cs);
    @(negedge clk);
    host_wr = 0; host_rd = 0;
  endtask

  task automatic wi(input logic [7:0] v); access(1, 0, bport(), v, "R4"); endtask
  task automatic wd(input logic [7:0] v); access(1, 0, bport() + 16'd1, v, "R4"); endtask
  task automatic rd_reg(input logic [7:0] idx, input string req);
    access(1, 0, bport(), idx, req);
    access(0, 1, bport() + 16'd1, 8'h00, req);
  endtask
  task automatic set_reg(input logic [7:0] idx, input logic [7:0] v);
    wi(idx); wd(v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R8 reset state
    #1 check_outputs("R8");
    chk("R8 cs", ser_cs, 2'b00);
    wi(8'h55);
    rd_reg(8'h26, "R8");
    chk("R8 self lo", host_rdata, 32'h2E);
    rd_reg(8'h27, "R8");
    set_reg(8'h07, 8'h04);
    rd_reg(8'h60, "R8");
    // R9 index-port read
    access(0, 1, bport(), 8'h00, "R9");
    // R3 writes while locked are dropped
    wi(8'hAA);
    wi(8'h07); wd(8'h09); wd(8'h33);
    access(0, 1, bport() + 16'd1, 8'h00, "R9");
    wi(8'h55);
    rd_reg(8'h07, "R3");
    chk("R3 devsel kept", host_rdata, 32'h04);
    // R6 missing device
    set_reg(8'h07, 8'h0C); set_reg(8'h30, 8'h5A); rd_reg(8'h30, "R6");
    chk("R6 bad dev read", host_rdata, 32'h00);
    // R11 separate banks
    set_reg(8'h07, 8'h04); set_reg(8'h70, 8'h17);
    set_reg(8'h07, 8'h05); set_reg(8'h70, 8'h29);
    rd_reg(8'h70, "R11");
    chk("R11 dev5", host_rdata, 32'h29);
    set_reg(8'h07, 8'h04); rd_reg(8'h70, "R11");
    chk("R11 dev4", host_rdata, 32'h17);
    // R5 global bank unaffected by device select
    set_reg(8'h2F, 8'hC3); set_reg(8'h07, 8'h02); rd_reg(8'h2F, "R5");
    chk("R5 global", host_rdata, 32'hC3);
    // R7 serial configuration
    set_reg(8'h07, 8'h04);
    set_reg(8'h30, 8'h01); set_reg(8'h60, 8'h03); set_reg(8'h61, 8'hF8);
    set_reg(8'h70, 8'h14);
    set_reg(8'h07, 8'h05);
    set_reg(8'h30, 8'h80); set_reg(8'h60, 8'hFF); set_reg(8'h61, 8'hFC);
    set_reg(8'h70, 8'h00);
    chk("R7 not yet", ser_en, 2'b00);
    wi(8'hAA);
    chk("R7 en", ser_en, 2'b11);
    chk("R7 base", ser_base, 32'hFFFC_03F8);
    chk("R7 irq", ser_irq, 8'h04);
    // R10 window edges
    access(0, 1, 16'h03F7, 8'h00, "R10");
    access(0, 1, 16'h03F8, 8'h00, "R10");
    access(1, 0, 16'h03FF, 8'h11, "R10");
    access(0, 1, 16'h0400, 8'h00, "R10");
    access(0, 1, 16'hFFFF, 8'h00, "R10");
    access(0, 1, 16'h0000, 8'h00, "R10");
    access(0, 1, 16'h0003, 8'h00, "R10");
    // R7 lock key while locked does nothing; disable keeps base
    wi(8'hAA);
    wi(8'h55);
    set_reg(8'h07, 8'h04); set_reg(8'h30, 8'h00); set_reg(8'h60, 8'h02);
    wi(8'hAA);
    chk("R7 disabled", ser_en, 2'b10);
    chk("R7 base kept", ser_base[15:0], 32'h03F8);
    access(0, 1, 16'h03F8, 8'h00, "R10");

    // random phase (R2-R7, R9-R11)
    for (int n = 0; n < 4000; n++) begin
      int sel;
      logic [7:0] pool [7];
      pool[0] = 8'h07; pool[1] = 8'h26; pool[2] = 8'h30; pool[3] = 8'h60;
      pool[4] = 8'h61; pool[5] = 8'h70; pool[6] = 8'($urandom);
      sel = int'($urandom % 16);
      case (sel)
        0:       access(1, 0, bport(), 8'h55, "R2");
        1:       access(1, 0, bport(), 8'hAA, "R2");
        2, 3, 4: begin
          logic [7:0] v;
          v = pool[$urandom % 7];
          if (v == 8'h55 || v == 8'hAA) v = 8'h07;
          access(1, 0, bport(), v, "R4");
        end
        5, 6, 7, 8:
          access(1, 0, bport() + 16'd1,
                 (m_idx == 8'h07) ? 8'($urandom % 14) : 8'($urandom), "R5");
        9, 10, 11: access(0, 1, bport() + 16'd1, 8'h00, "R4");
        12:      access(0, 1, bport(), 8'h00, "R9");
        default: access($urandom % 2 == 0, 1'b1, 16'($urandom), 8'($urandom), "R1");
      endcase
    end

    // R1 strap selects the alternate base
    strap_alt = 1'b1;
    do_reset();
    access(1, 0, 16'h002E, 8'h55, "R1");
    access(0, 1, 16'h002F, 8'h00, "R1");
    wi(8'h55);
    rd_reg(8'h26, "R1");
    chk("R1 alt base lo", host_rdata, 32'h4E);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule